// File: doc/BRIEF.md
# Change-of-State Latched Alarm Status Bank

This block collects the live alarm conditions of an eight-channel line interface and presents them to a host processor as one 8-bit status register per channel. Each channel has four alarm inputs: transmitter driver fault, loss of incoming signal, line coding error, and loss of the transmit clock. Each input passes through a two-flop synchroniser. The synchronised level then appears directly in the register.

Next to each live bit sits a sticky flag. The flag latches whenever that alarm changes level, on a rising or a falling edge, and it stays set until the host reads the register. A read returns the register contents and clears the sticky half in the same access. The live half is never cleared by a read. A change that lands in the same cycle as the clearing read is kept, so no event is lost.

One registered interrupt line is high while any sticky flag in the bank is set. The host reaches the bank through a small parallel bus with a 5-bit address, a read strobe and 8-bit read data.

Top module: `cos_status_bank`

## Requirements
- R1: Channel c takes its alarms on `alarmIn[4c+3:4c]`, in this order: bit 3 is driver fault, bit 2 is signal loss, bit 1 is coding error, bit 0 is transmit clock loss. After a two-flop synchroniser, these levels show in register bits 7..4 in the same order, two clock edges after the input changes.
- R2: The channel registers sit at these addresses: channel 0 at 0x02, 1 at 0x05, 2 at 0x08, 3 at 0x0B, 4 at 0x12, 5 at 0x15, 6 at 0x18, 7 at 0x1B.
- R3: Register bits 3..0 are sticky flags for the alarms in bits 7..4, one to one. A flag is set one edge after its synchronised alarm changes level, whether the alarm rises or falls. An alarm that holds its level sets nothing.
- R4: While `rdEn` is high, `rdData` shows the addressed register in the same cycle. The clock edge that ends the read clears that register's sticky bits. Its live bits are left unchanged.
- R5: A level change that sets a sticky flag on the same edge as a clearing read of that register leaves the flag set.
- R6: `irq` is a registered OR of all 32 sticky flags. It rises on the edge that sets the first flag and falls on the edge that clears the last one.
- R7: A read of any address not listed in R2 returns 0x00 and changes no sticky flag.
- R8: While `rstN` is low, every register bit and `irq` are 0.
- R9: A read clears only the addressed channel's sticky flags. The flags of all other channels are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| alarmIn | input | 32 | Live alarm levels, four per channel |
| rdEn | input | 1 | Read strobe; the read clears sticky bits at the end of the cycle |
| rdAddr | input | 5 | Register address |
| rdData | output | 8 | Read data; 0 when idle or unmapped |
| irq | output | 1 | High while any sticky flag is set |

## Verification
The assertions assume that `rdEn` and `rdAddr` are synchronous to `clk` and steady through each cycle. They also assume that every alarm level seen after the synchroniser is a clean level. Under those conditions, each difference between the synchronised level and its delayed copy is one real event. The bench drives every input on the falling clock edge. It holds each alarm pattern for several cycles before it reads, so each change becomes exactly one sticky event. It uses deliberate timing only where a change must coincide with a clearing read.

// File: rtl/cos_pkg.sv
package cos_pkg;
  parameter int NUM_CH  = 8;
  parameter int ALARM_N = 4;
  parameter int ADDR_W  = 5;
  parameter int DATA_W  = 2 * ALARM_N;
  parameter int CH_W    = $clog2(NUM_CH);
  parameter int TOTAL_N = NUM_CH * ALARM_N;

  typedef struct packed {
    logic              rdHit;
    logic [CH_W-1:0]   chSel;
    logic [NUM_CH-1:0] clrVec;
  } ctrlStrobes_t;

  // Channel address: groups of four, step of three, offset two, upper group at 0x10
  function automatic logic [ADDR_W-1:0] chAddr(input int c);
    return ADDR_W'(((c / 4) * 16) + ((c % 4) * 3) + 2);
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1Q;
  logic [WIDTH-1:0] stage2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Q <= '0;
      stage2Q <= '0;
    end else begin
      stage1Q <= asyncIn;
      stage2Q <= stage1Q;
    end
  end

  assign syncOut = stage2Q;
endmodule

// File: rtl/cos_ctrl.sv
module cos_ctrl
  import cos_pkg::*;
(
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rdAddr == chAddr(c)) begin
        strobes.rdHit     = rdEn;
        strobes.chSel     = CH_W'(c);
        strobes.clrVec[c] = rdEn;
      end
    end
  end
endmodule

// File: rtl/cos_datapath.sv
module cos_datapath
  import cos_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [TOTAL_N-1:0] liveQ,
  input  ctrlStrobes_t       strobes,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  logic [TOTAL_N-1:0] prevQ;
  logic [TOTAL_N-1:0] stickyQ;
  logic [TOTAL_N-1:0] stickyD;
  logic [TOTAL_N-1:0] changeVec;
  logic [TOTAL_N-1:0] clrMask;
  logic               irqQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign clrMask[c*ALARM_N +: ALARM_N] = {ALARM_N{strobes.clrVec[c]}};
  end

  assign changeVec = liveQ ^ prevQ;
  // Set wins over clear so an event coinciding with a read survives
  assign stickyD   = (stickyQ & ~clrMask) | changeVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= '0;
      stickyQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      prevQ   <= liveQ;
      stickyQ <= stickyD;
      irqQ    <= |stickyD;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdHit) begin
      rdData = {liveQ[int'(strobes.chSel)*ALARM_N +: ALARM_N],
                stickyQ[int'(strobes.chSel)*ALARM_N +: ALARM_N]};
    end
  end

  assign irq = irqQ;
endmodule

// File: rtl/cos_status_bank.sv
module cos_status_bank
  import cos_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [TOTAL_N-1:0] alarmIn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  logic [TOTAL_N-1:0] liveQ;
  ctrlStrobes_t       strobes;

  cos_sync #(.WIDTH(TOTAL_N)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(alarmIn), .syncOut(liveQ)
  );

  cos_ctrl u_ctrl (
    .rdEn(rdEn), .rdAddr(rdAddr), .strobes(strobes)
  );

  cos_datapath u_dp (
    .clk(clk), .rstN(rstN), .liveQ(liveQ), .strobes(strobes),
    .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/cos_status_bank_chk.sv
module cos_status_bank_chk
  import cos_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [DATA_W-1:0]  rdData,
  input logic               irq,
  input logic [TOTAL_N-1:0] liveQ,
  input logic [TOTAL_N-1:0] prevQ,
  input logic [TOTAL_N-1:0] stickyQ
);
  function automatic logic isMapped(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int c = 0; c < NUM_CH; c++) if (a == chAddr(c)) hit = 1'b1;
    return hit;
  endfunction

  // R3: every level change leaves its sticky flag set on the following edge
  a_r3_change_sets: assert property (@(posedge clk) disable iff (!rstN)
    (liveQ != prevQ) |=> ((stickyQ & $past(liveQ ^ prevQ)) == $past(liveQ ^ prevQ)));

  // R6: a flag present before a non-reading edge keeps irq high
  a_r6_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    ((|stickyQ) && !rdEn) |=> irq);

  // R7: unmapped reads return zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !isMapped(rdAddr)) |-> (rdData == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R1: live nibble reflects the synchronised alarms on a read
    a_r1_live_nibble: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && rdAddr == chAddr(c)) |-> (rdData[DATA_W-1 -: ALARM_N] == liveQ[c*ALARM_N +: ALARM_N]));

    // R4: a read with no coinciding change empties the sticky nibble
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && rdAddr == chAddr(c) && liveQ[c*ALARM_N +: ALARM_N] == prevQ[c*ALARM_N +: ALARM_N])
      |=> (stickyQ[c*ALARM_N +: ALARM_N] == '0));

    // R9: without a read of this channel no sticky flag drops
    a_r9_flags_kept: assert property (@(posedge clk) disable iff (!rstN)
      !(rdEn && rdAddr == chAddr(c))
      |=> ((stickyQ[c*ALARM_N +: ALARM_N] & $past(stickyQ[c*ALARM_N +: ALARM_N]))
           == $past(stickyQ[c*ALARM_N +: ALARM_N])));
  end
endmodule

bind cos_status_bank cos_status_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .irq(irq), .liveQ(liveQ), .prevQ(u_dp.prevQ), .stickyQ(u_dp.stickyQ)
);

// File: tb/cos_status_bank_tb.sv
module cos_status_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] alarmIn = '0;
  logic        rdEn = 1'b0;
  logic [4:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        irq;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [3:0] model [8];

  always #2 clk = ~clk;

  cos_status_bank u_dut (
    .clk(clk), .rstN(rstN), .alarmIn(alarmIn), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  // {channel, nibble}: the nibble is driver fault, signal loss, coding error, clock loss
  localparam logic [6:0] VECS [12] = '{
    {3'd0, 4'b1000}, {3'd0, 4'b0000}, {3'd1, 4'b0100}, {3'd2, 4'b0010},
    {3'd3, 4'b0001}, {3'd4, 4'b1111}, {3'd4, 4'b1111}, {3'd5, 4'b1010},
    {3'd6, 4'b0101}, {3'd7, 4'b1100}, {3'd7, 4'b0011}, {3'd3, 4'b0000}
  };

  function automatic logic [4:0] addrOf(input int c);
    return 5'(((c / 4) * 16) + ((c % 4) * 3) + 2);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doRead(input logic [4:0] a, output logic [7:0] d);
    rdAddr = a;
    rdEn   = 1'b1;
    #1 d = rdData;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setCh(input int c, input logic [3:0] nib);
    alarmIn[c*4 +: 4] = nib;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int c = 0; c < 8; c++) model[c] = '0;
    // R8: the reset state, checked while reset is still applied
    edges(2);
    rdAddr = addrOf(0); rdEn = 1'b1;
    #1 check("R8 reset reg", rdData, 8'h00);
    check("R8 reset irq", {7'd0, irq}, 8'h00);
    rdEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    edges(2);
    for (int c = 0; c < 8; c++) begin
      doRead(addrOf(c), d);
      check("R2 R8 post-reset reg", d, 8'h00);
    end

    // Table: R1 R2 R3 R4 R6
    for (int i = 0; i < 12; i++) begin
      int c;
      logic [3:0] nib;
      c   = int'(VECS[i][6:4]);
      nib = VECS[i][3:0];
      setCh(c, nib);
      edges(4);
      check("R6 irq after change", {7'd0, irq}, {7'd0, nib != model[c]});
      doRead(addrOf(c), d);
      check("R1 R3 register", d, {nib, nib ^ model[c]});
      doRead(addrOf(c), d);
      check("R4 sticky cleared live kept", d, {nib, 4'b0000});
      check("R6 irq falls after read", {7'd0, irq}, 8'h00);
      model[c] = nib;
    end

    // R7: unmapped reads return zero and clear nothing (ch5 1010 -> 0000)
    setCh(5, 4'b0000);
    edges(4);
    doRead(5'h00, d);  check("R7 unmapped 0x00", d, 8'h00);
    doRead(5'h1F, d);  check("R7 unmapped 0x1F", d, 8'h00);
    doRead(5'h03, d);  check("R7 unmapped 0x03", d, 8'h00);
    check("R7 irq kept", {7'd0, irq}, 8'h01);
    doRead(addrOf(5), d);
    check("R7 flags intact", d, 8'h0A);
    model[5] = 4'b0000;

    // R9: a read clears only its own channel
    setCh(1, 4'b0000);
    setCh(6, 4'b0001);
    edges(4);
    doRead(addrOf(1), d);
    check("R9 ch1 read", d, 8'h04);
    check("R9 irq still high", {7'd0, irq}, 8'h01);
    doRead(addrOf(6), d);
    check("R9 ch6 kept", d, 8'h14);
    check("R9 irq low", {7'd0, irq}, 8'h00);

    // R5: a change that lands on the clearing read edge survives (ch2 0010 -> 1010)
    setCh(2, 4'b1010);
    edges(2);
    doRead(addrOf(2), d);
    check("R5 read during change", d, 8'hA0);
    check("R5 irq set", {7'd0, irq}, 8'h01);
    doRead(addrOf(2), d);
    check("R5 flag survived", d, 8'hA8);

    $display("  End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule